// File: doc/BRIEF.md
# Masked Cursor Color-Key Substitution Stage

This stage sits in a 24-bit graphics pixel stream. It compares each incoming pixel with a programmed key value. The comparison only looks at the bit positions that a programmable mask enables. When the enabled bits agree, the pixel is swapped for one of two programmed cursor colors. Pixels that do not agree leave the stage unchanged. The result appears one clock after the pixel enters, and it keeps its valid qualifier.

The cursor color is chosen separately for every pixel. A 5-bit bit-select value names one bit position of the incoming pixel. If that bit is 0, the first cursor color is used. If it is 1, the second cursor color is used. This lets the cursor shape and its two-tone coloring be encoded directly in the graphics data.

Software programs the stage through a simple write port. The port takes an address and a 32-bit data word.

Top module: `cursor_key_sub`

## Requirements
- R1: After an active-low reset, `out_valid` is 0 and key, mask, both cursor colors and the bit-select all hold 0. With no writes, every valid pixel therefore leaves the stage as 000000h.
- R2: A valid pixel is a hit when `((in_pix ^ key) & mask) == 0`. In other words, only the bit positions where the mask holds 1 are compared.
- R3: With the mask equal to 000000h, every valid pixel is a hit and is replaced by a cursor color.
- R4: On a hit with bit-select `s < 24`, the output is cursor color A when `in_pix[s]` is 0 and cursor color B when `in_pix[s]` is 1.
- R5: On a hit with bit-select 24 to 31, the output is cursor color A.
- R6: A valid pixel that is not a hit appears unchanged on `out_pix`.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock. `out_pix` keeps its value in any cycle that follows an invalid input.
- R8: A write updates the register at the clock edge where `wr_en` is sampled. A pixel sampled at that same edge still uses the old value, and a pixel sampled at the next edge uses the new value.
- R9: The register addresses are: key 0, mask 1, cursor color A 2, cursor color B 3, control 4. The key, mask and color words keep only `wr_data[23:0]`, and their bits 31:24 are ignored. The control word keeps only the bit-select in `wr_data[28:24]`.
- R10: A write to addresses 5 to 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output pixel |

## Verification
The hardest case to reach from the ports is a hit under a partial mask whose chosen color depends on the selected bit. Random pixels almost never equal a 24-bit key. The stimulus therefore builds pixels from the masked key bits and fills the unmasked positions with random values. It also places the bit-select both inside and outside the masked field. Writes are issued in the same cycle as pixels, so the old-value/new-value boundary at the register edge is exercised.

// File: rtl/cck_pkg.sv
// Package: shared constants and register address codes for the
// cursor color-key stage. Assumes a 3-bit register address space.
package cck_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        ADR_KEY  = 3'd0,
        ADR_MASK = 3'd1,
        ADR_COLA = 3'd2,
        ADR_COLB = 3'd3,
        ADR_CTRL = 3'd4
    } cck_addr_e;

    localparam int NUM_WORDS = 4;   // key, mask, color A, color B
endpackage

// File: rtl/cck_regs.sv
// Module: cck_regs
// Holds the key, mask, two cursor colors and the bit-select.
// Assumes address codes from cck_pkg; pixel-wide words keep only the
// low PIX_W bits; the bit-select sits at SEL_LSB in the control word.
module cck_regs
    import cck_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int SEL_W   = 5,
    parameter int SEL_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [PIX_W-1:0]  key,
    output logic [PIX_W-1:0]  mask,
    output logic [PIX_W-1:0]  col_a,
    output logic [PIX_W-1:0]  col_b,
    output logic [SEL_W-1:0]  sel
);
    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
            logic [PIX_W-1:0] q;
            // Capture the low pixel-wide field on a write to this word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))
                    q <= wr_data[PIX_W-1:0];
            end
        end
    endgenerate

    assign key   = g_word[0].q;
    assign mask  = g_word[1].q;
    assign col_a = g_word[2].q;
    assign col_b = g_word[3].q;

    // Capture the bit-select field of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (wr_en && wr_addr == ADR_CTRL)
            sel <= wr_data[SEL_LSB+SEL_W-1:SEL_LSB];
    end
endmodule

// File: rtl/cck_match.sv
// Module: cck_match
// Combinational masked key compare and cursor color choice.
// Assumes a bit-select at or above PIX_W picks color A.
module cck_match #(
    parameter int PIX_W = 24,
    parameter int SEL_W = 5
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] key,
    input  logic [PIX_W-1:0] mask,
    input  logic [PIX_W-1:0] col_a,
    input  logic [PIX_W-1:0] col_b,
    input  logic [SEL_W-1:0] sel,
    output logic [PIX_W-1:0] result
);
    logic hit;
    logic pick_b;

    // A hit means the masked bits of pixel and key agree.
    always_comb hit = ((pix ^ key) & mask) == '0;

    // Pick the pixel bit named by sel; out-of-range selects give 0.
    always_comb begin
        pick_b = 1'b0;
        for (int i = 0; i < PIX_W; i++)
            if (sel == SEL_W'(i))
                pick_b = pix[i];
    end

    // Replace on a hit, otherwise pass the pixel through.
    always_comb result = hit ? (pick_b ? col_b : col_a) : pix;
endmodule

// File: rtl/cursor_key_sub.sv
// Module: cursor_key_sub
// Top of the masked cursor color-key stage: register bank, match
// logic and a one-cycle output register. Assumes writes and pixels
// share clk; a write affects pixels sampled from the next edge on.
module cursor_key_sub
    import cck_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int SEL_W   = 5,
    parameter int SEL_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    logic [PIX_W-1:0] key_w, mask_w, col_a_w, col_b_w, result_w;
    logic [SEL_W-1:0] sel_w;

    cck_regs #(.PIX_W(PIX_W), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .key     (key_w),
        .mask    (mask_w),
        .col_a   (col_a_w),
        .col_b   (col_b_w),
        .sel     (sel_w)
    );

    cck_match #(.PIX_W(PIX_W), .SEL_W(SEL_W)) u_match (
        .pix    (in_pix),
        .key    (key_w),
        .mask   (mask_w),
        .col_a  (col_a_w),
        .col_b  (col_b_w),
        .sel    (sel_w),
        .result (result_w)
    );

    // Delay the qualifier by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Register the result only for valid pixels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_pix <= '0;
        else if (in_valid)
            out_pix <= result_w;
    end
endmodule

// File: rtl/cck_checker.sv
// Module: cck_checker
// Temporal properties of cursor_key_sub, bound to its ports and its
// internal register outputs.
module cck_checker #(
    parameter int PIX_W = 24,
    parameter int SEL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             in_valid,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic [PIX_W-1:0] key,
    input logic [PIX_W-1:0] mask,
    input logic [PIX_W-1:0] col_a,
    input logic [PIX_W-1:0] col_b,
    input logic [SEL_W-1:0] sel
);
    localparam logic [SEL_W-1:0] FIRST_OUT = SEL_W'(PIX_W);

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                            // R7
    AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_pix)));                    // R7
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (((in_pix ^ key) & mask) != '0)) |=> out_pix == $past(in_pix)); // R6
    AST_OPEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask == '0) |=> (out_pix == $past(col_a) || out_pix == $past(col_b))); // R3
    AST_FAR_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel >= FIRST_OUT && (((in_pix ^ key) & mask) == '0)) |=> out_pix == $past(col_a)); // R5
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 3'd0) |=> $stable(key));                      // R8
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 3'd4) |=> $stable(sel));                      // R10
endmodule

bind cursor_key_sub cck_checker #(.PIX_W(PIX_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .key       (key_w),
    .mask      (mask_w),
    .col_a     (col_a_w),
    .col_b     (col_b_w),
    .sel       (sel_w)
);

// File: tb/cursor_key_sub_test.sv
// Bench: behavioural reference model compared on every clock.
module cursor_key_sub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic [23:0] out_pix;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // reference model state
    int m_key = 0, m_mask = 0, m_ca = 0, m_cb = 0, m_sel = 0;
    bit exp_valid = 0;
    int exp_pix = 0;

    always #4 clk = ~clk;   // 125 MHz

    cursor_key_sub uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int model_out(int p);
        int b;
        if (((p ^ m_key) & m_mask) != 0) return p;          // R6
        if (m_sel >= 24) return m_ca;                        // R5
        b = (p >> m_sel) & 1;                                // R4
        return b ? m_cb : m_ca;
    endfunction

    // Model: output from old register values, then apply the write (R8).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = 0; m_mask = 0; m_ca = 0; m_cb = 0; m_sel = 0;
            exp_valid = 0; exp_pix = 0;
        end else begin
            exp_valid = in_valid;
            if (in_valid) exp_pix = model_out(int'(in_pix));
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_key  = int'(wr_data[23:0]);
                    3'd1: m_mask = int'(wr_data[23:0]);
                    3'd2: m_ca   = int'(wr_data[23:0]);
                    3'd3: m_cb   = int'(wr_data[23:0]);
                    3'd4: m_sel  = int'(wr_data[28:24]);
                    default: ;                               // R10
                endcase
            end
        end
    end

    // Compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== exp_valid) begin
                fails++;
                $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_valid);
            end else if (out_pix !== 24'(exp_pix)) begin
                fails++;
                $display("FAIL %s out_pix actual=%06h expected=%06h", tag, out_pix, 24'(exp_pix));
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        wr_en = 0; in_valid = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; in_valid = 0;
    endtask

    task automatic px(input logic [23:0] p);
        @(negedge clk);
        wr_en = 0; in_valid = 1; in_pix = p;
    endtask

    // Pixel that hits: masked key bits plus random bits elsewhere.
    task automatic px_hit();
        logic [23:0] r;
        r = 24'($urandom);
        px((24'(m_key) & 24'(m_mask)) | (r & ~24'(m_mask)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: registers at zero -> every pixel becomes 000000h
        tag = "R1";
        px(24'h123456); px(24'hABCDEF); px(24'hFFFFFF);
        // R7: bubbles keep out_valid low and out_pix steady
        tag = "R7";
        idle(); idle(); px(24'h0F0F0F); idle(); px(24'h010101); idle();
        // R9: reserved upper bits ignored
        tag = "R9";
        wr(3'd0, 32'hFF_12_34_56);
        wr(3'd1, 32'hAA_FF_FF_FF);
        wr(3'd2, 32'h77_A0_A0_A0);
        wr(3'd3, 32'h55_B0_B0_B0);
        wr(3'd4, 32'hE0_00_FF_FF);           // bit-select 0, junk elsewhere
        idle();
        px(24'h123456); px(24'h123457); px(24'h123450);
        wr(3'd4, 32'h01_00_00_00 | 32'hE0_00_00_00 | (32'd1 << 24)); // sel 1
        px(24'h123456); px(24'h123454);
        // R2: partial mask compare
        tag = "R2";
        wr(3'd1, 32'h0000_FF00);
        wr(3'd4, 32'd8 << 24);               // select bit 8, inside mask
        px(24'h003400); px(24'hFF34FF); px(24'h003500); px(24'h123456);
        for (int i = 0; i < 40; i++) begin px_hit(); px(24'($urandom)); end
        // R4: select a bit outside the mask
        tag = "R4";
        wr(3'd4, 32'd23 << 24);
        for (int i = 0; i < 40; i++) px_hit();
        px(24'h803400); px(24'h003400);
        // R5: out-of-range selects pick color A
        tag = "R5";
        wr(3'd4, 32'd24 << 24);
        px(24'hFF34FF); px(24'h003400);
        wr(3'd4, 32'd31 << 24);
        for (int i = 0; i < 20; i++) px_hit();
        // R6: misses pass unchanged
        tag = "R6";
        wr(3'd1, 32'h00FF_FFFF);
        for (int i = 0; i < 30; i++) px(24'($urandom));
        // R3: open mask -> all hit
        tag = "R3";
        wr(3'd1, 32'h0);
        wr(3'd4, 32'd5 << 24);
        for (int i = 0; i < 40; i++) px(24'($urandom));
        // R8: write and pixel in the same cycle
        tag = "R8";
        @(negedge clk);
        wr_en = 1; wr_addr = 3'd2; wr_data = 32'h00C0FFEE;
        in_valid = 1; in_pix = 24'h000000;   // uses old color A
        px(24'h000000);                      // uses new color A
        @(negedge clk);
        wr_en = 1; wr_addr = 3'd1; wr_data = 32'h00FFFFFF;
        in_valid = 1; in_pix = 24'h111111;   // old mask 0 -> hit
        px(24'h111111);                      // new full mask -> miss
        // R10: unused addresses change nothing
        tag = "R10";
        wr(3'd5, 32'hFFFFFFFF); wr(3'd6, 32'h0); wr(3'd7, 32'h12345678);
        px(24'h123456); px(24'h111111); px_hit(); px(24'h123457);
        // random mixed traffic
        tag = "R2";
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 6)
                0: wr(3'($urandom % 8), $urandom);
                1: idle();
                2, 3: px_hit();
                default: px(24'($urandom));
            endcase
        end
        idle(); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule